// File: doc/BRIEF.md
# Peripheral Write Strobe Stretcher

This block sits between a fast bus master and a slow latching peripheral that needs a long write pulse and some data hold time after its latching edge. The master's write strobe is qualified by an active-low select. The moment that qualified strobe becomes active (the falling edge of the master's strobe), the block does three things. It captures the bus data into a holding register. It pulls its ready output low to stall the master. It drives the peripheral strobe low. The master may release its own strobe and data long before the peripheral is done, because the peripheral only ever sees the captured copy.

The peripheral strobe stays low for a programmed number of system clock cycles and then rises; that rising edge is the latching edge. The captured data stays on the peripheral bus for a second programmed count, and then ready returns high. Both counts are clamped from below by floors that are derived at elaboration time from the clock period and the minimum pulse and hold times. A programming error can therefore never shorten the pulse below the physical minimum. A write that arrives while a sequence is running is dropped, and a sticky flag records it. Every part of the block is synchronous to one system clock. An optional synchronizer depth delays the qualified strobe and the data by the same number of cycles.

Top module: `wr_strobe_stretch`

## Requirements
- R1: While reset is asserted and right after it, per_wr_n is 1, bus_ready is 1, per_data is 0 and err_overrun is 0.
- R2: A write is qualified when bus_cs_n and bus_wr_n are both 0. With SYNC_STAGES=0, on the first clock edge that samples a qualified write following a cycle without one, per_wr_n goes to 0 and bus_ready goes to 0 together.
- R3: per_data takes the bus_data value sampled on that triggering edge and holds it unchanged until the next accepted write, whatever bus_data does meanwhile.
- R4: per_wr_n stays 0 for exactly max(cfg_low_cyc, LOW_FLOOR) cycles, where LOW_FLOOR = ceil(MIN_PULSE_PS / CLK_PS), at least 1 (113 with the defaults).
- R5: After per_wr_n rises, bus_ready stays 0 for exactly max(cfg_hold_cyc, HOLD_FLOOR) further cycles, where HOLD_FLOOR = ceil(MIN_HOLD_PS / CLK_PS), at least 1 (7 with the defaults).
- R6: When the hold count expires, bus_ready returns to 1 with per_wr_n at 1, and both stay there while no new write is qualified. A write triggered on the very first cycle that ready is back high is accepted.
- R7: A new qualified write edge during the low or hold phase is ignored: per_data and the phase lengths are unaffected. err_overrun goes to 1 and stays 1 until reset.
- R8: bus_wr_n going low while bus_cs_n is 1 has no effect on any output.
- R9: A qualified write that is already active when reset is released is not treated as a new edge.
- R10: Both counts are taken at the triggering edge. Changing cfg_low_cyc or cfg_hold_cyc during a sequence does not alter that sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_cs_n | input | 1 | Active-low select from the address decoder |
| bus_wr_n | input | 1 | Active-low write strobe of the bus master |
| bus_data | input | DATA_W | Write data from the bus master |
| cfg_low_cyc | input | CNT_W | Programmed strobe-low length in cycles |
| cfg_hold_cyc | input | CNT_W | Programmed post-strobe hold length in cycles |
| bus_ready | output | 1 | High when the master may proceed; low stalls it |
| per_wr_n | output | 1 | Stretched active-low strobe to the peripheral |
| per_data | output | DATA_W | Captured data presented to the peripheral |
| err_overrun | output | 1 | Sticky flag: a write was dropped while busy |

## Verification
The properties assume that the select and strobe inputs are free of X and, with no synchronizer stages, change away from the rising clock edge. They also assume that the floors were computed for the clock the block actually runs on. The bench drives every input on the falling clock edge. It asserts the master strobe for about thirty cycles, which is shorter than any stretched pulse, so it behaves like a fast master. It times the extra strobe edges that test overruns so that they always fall inside the low phase, and it starts a fresh write either after idle gaps or on the first cycle ready returns.

// File: rtl/wss_pkg.sv
package wss_pkg;

   typedef enum logic [1:0] {
      ST_IDLE       = 2'd0,
      ST_STROBE_LOW = 2'd1,
      ST_HOLD       = 2'd2,
      ST_DONE       = 2'd3
   } wss_state_e;

   // Ceiling division for elaboration-time cycle floors.
   function automatic int ceil_div(input int num, input int den);
      return (num + den - 1) / den;
   endfunction

   // Clamp a cycle floor to at least one cycle.
   function automatic int at_least_one(input int v);
      return (v < 1) ? 1 : v;
   endfunction

endpackage

// File: rtl/wss_edge_qual.sv
module wss_edge_qual #(
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              wr_n,
   input  logic [DATA_W-1:0] data_in,
   output logic              trig,
   output logic [DATA_W-1:0] data_al
);

   logic qual_raw;
   logic qual_al;
   logic qual_prev;

   assign qual_raw = ~cs_n & ~wr_n;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign qual_al = qual_raw;
         assign data_al = data_in;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] q_pipe;
         logic [DATA_W-1:0]      d_pipe [SYNC_STAGES];

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               q_pipe <= '1;
               for (int i = 0; i < SYNC_STAGES; i++) begin
                  d_pipe[i] <= '0;
               end
            end else begin
               q_pipe[0] <= qual_raw;
               d_pipe[0] <= data_in;
               for (int i = 1; i < SYNC_STAGES; i++) begin
                  q_pipe[i] <= q_pipe[i-1];
                  d_pipe[i] <= d_pipe[i-1];
               end
            end
         end

         assign qual_al = q_pipe[SYNC_STAGES-1];
         assign data_al = d_pipe[SYNC_STAGES-1];
      end
   endgenerate

   // Previous value resets to "active" so a strobe held through reset
   // is not mistaken for a fresh edge.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         qual_prev <= 1'b1;
      end else begin
         qual_prev <= qual_al;
      end
   end

   assign trig = qual_al & ~qual_prev;

endmodule

// File: rtl/wss_count_sel.sv
module wss_count_sel #(
   parameter int CNT_W = 8,
   parameter int FLOOR = 1
) (
   input  logic [CNT_W-1:0] cfg,
   output logic [CNT_W-1:0] eff_m1
);

   localparam logic [CNT_W-1:0] FLOOR_V = CNT_W'(FLOOR);
   localparam logic [CNT_W-1:0] ONE_V   = CNT_W'(1);

   logic [CNT_W-1:0] eff;

   generate
      if (FLOOR > 1) begin : g_floor
         assign eff = (cfg < FLOOR_V) ? FLOOR_V : cfg;
      end else begin : g_nonzero
         assign eff = (cfg == '0) ? ONE_V : cfg;
      end
   endgenerate

   assign eff_m1 = eff - ONE_V;

endmodule

// File: rtl/wss_seq_fsm.sv
module wss_seq_fsm
   import wss_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int CNT_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              trig,
   input  logic [DATA_W-1:0] data_in,
   input  logic [CNT_W-1:0]  low_m1,
   input  logic [CNT_W-1:0]  hold_m1,
   output logic              per_wr_n,
   output logic [DATA_W-1:0] per_data,
   output logic              ready,
   output logic              err
);

   wss_state_e       state;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] hold_q;
   logic             cnt_zero;
   logic             busy;

   assign cnt_zero = (cnt == '0);
   assign busy     = (state == ST_STROBE_LOW) || (state == ST_HOLD);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         cnt      <= '0;
         hold_q   <= '0;
         per_wr_n <= 1'b1;
         per_data <= '0;
         ready    <= 1'b1;
      end else begin
         unique case (state)
            ST_IDLE, ST_DONE: begin
               if (trig) begin
                  state    <= ST_STROBE_LOW;
                  cnt      <= low_m1;
                  hold_q   <= hold_m1;
                  per_data <= data_in;
                  per_wr_n <= 1'b0;
                  ready    <= 1'b0;
               end else begin
                  state <= ST_IDLE;
               end
            end
            ST_STROBE_LOW: begin
               if (cnt_zero) begin
                  state    <= ST_HOLD;
                  cnt      <= hold_q;
                  per_wr_n <= 1'b1;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            ST_HOLD: begin
               if (cnt_zero) begin
                  state <= ST_DONE;
                  ready <= 1'b1;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            default: begin
               state <= ST_IDLE;
            end
         endcase
      end
   end

   // Sticky overrun flag: only reset clears it.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err <= 1'b0;
      end else if (trig && busy) begin
         err <= 1'b1;
      end
   end

endmodule

// File: rtl/wr_strobe_stretch.sv
module wr_strobe_stretch
   import wss_pkg::*;
#(
   parameter int DATA_W       = 8,
   parameter int CNT_W        = 8,
   parameter int CLK_PS       = 8000,
   parameter int MIN_PULSE_PS = 900000,
   parameter int MIN_HOLD_PS  = 50000,
   parameter int SYNC_STAGES  = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_cs_n,
   input  logic              bus_wr_n,
   input  logic [DATA_W-1:0] bus_data,
   input  logic [CNT_W-1:0]  cfg_low_cyc,
   input  logic [CNT_W-1:0]  cfg_hold_cyc,
   output logic              bus_ready,
   output logic              per_wr_n,
   output logic [DATA_W-1:0] per_data,
   output logic              err_overrun
);

   localparam int LOW_FLOOR  = at_least_one(ceil_div(MIN_PULSE_PS, CLK_PS));
   localparam int HOLD_FLOOR = at_least_one(ceil_div(MIN_HOLD_PS, CLK_PS));
   localparam int CNT_MAX    = (1 << CNT_W) - 1;

   generate
      if (DATA_W < 1) begin : g_bad_data_w
         $error("DATA_W must be at least 1");
      end
      if (CNT_W < 1 || CNT_W > 16) begin : g_bad_cnt_w
         $error("CNT_W must lie in 1..16");
      end
      if (CLK_PS < 1) begin : g_bad_clk
         $error("CLK_PS must be positive");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must lie in 0..4");
      end
      if (LOW_FLOOR > CNT_MAX) begin : g_bad_low_floor
         $error("strobe-low floor does not fit in CNT_W bits");
      end
      if (HOLD_FLOOR > CNT_MAX) begin : g_bad_hold_floor
         $error("hold floor does not fit in CNT_W bits");
      end
   endgenerate

   logic              trig;
   logic [DATA_W-1:0] data_al;
   logic [CNT_W-1:0]  low_m1;
   logic [CNT_W-1:0]  hold_m1;

   wss_edge_qual #(
      .DATA_W      (DATA_W),
      .SYNC_STAGES (SYNC_STAGES)
   ) u_edge (
      .clk     (clk),
      .rst_n   (rst_n),
      .cs_n    (bus_cs_n),
      .wr_n    (bus_wr_n),
      .data_in (bus_data),
      .trig    (trig),
      .data_al (data_al)
   );

   wss_count_sel #(
      .CNT_W (CNT_W),
      .FLOOR (LOW_FLOOR)
   ) u_low_sel (
      .cfg    (cfg_low_cyc),
      .eff_m1 (low_m1)
   );

   wss_count_sel #(
      .CNT_W (CNT_W),
      .FLOOR (HOLD_FLOOR)
   ) u_hold_sel (
      .cfg    (cfg_hold_cyc),
      .eff_m1 (hold_m1)
   );

   wss_seq_fsm #(
      .DATA_W (DATA_W),
      .CNT_W  (CNT_W)
   ) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .trig     (trig),
      .data_in  (data_al),
      .low_m1   (low_m1),
      .hold_m1  (hold_m1),
      .per_wr_n (per_wr_n),
      .per_data (per_data),
      .ready    (bus_ready),
      .err      (err_overrun)
   );

endmodule

// File: rtl/wr_strobe_stretch_chk.sv
module wr_strobe_stretch_chk #(
   parameter int DATA_W     = 8,
   parameter int CNT_W      = 8,
   parameter int LOW_FLOOR  = 1,
   parameter int HOLD_FLOOR = 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_ready,
   input logic              per_wr_n,
   input logic [DATA_W-1:0] per_data,
   input logic              err_overrun
);

   localparam int RUN_W = CNT_W + 2;

   logic [RUN_W-1:0] low_run;
   logic [RUN_W-1:0] hold_run;

   // Run-length counters measure the phases without deep $past.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         low_run  <= '0;
         hold_run <= '0;
      end else begin
         if (per_wr_n) begin
            low_run <= '0;
         end else if (low_run != '1) begin
            low_run <= low_run + 1'b1;
         end
         if (!(per_wr_n && !bus_ready)) begin
            hold_run <= '0;
         end else if (hold_run != '1) begin
            hold_run <= hold_run + 1'b1;
         end
      end
   end

   AST_STROBE_INSIDE_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
      !per_wr_n |-> !bus_ready) else $error("strobe low outside wait"); // R6

   AST_START_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(per_wr_n) |-> $fell(bus_ready)) else $error("strobe fell without stall"); // R2

   AST_MIN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(per_wr_n) |-> (low_run >= RUN_W'(LOW_FLOOR))) else $error("strobe too short"); // R4

   AST_MIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_ready) |-> (hold_run >= RUN_W'(HOLD_FLOOR))) else $error("hold too short"); // R5

   AST_DATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_ready && !$past(bus_ready)) |-> $stable(per_data)) else $error("data moved while busy"); // R3

   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      err_overrun |=> err_overrun) else $error("overrun flag cleared"); // R7

endmodule

bind wr_strobe_stretch wr_strobe_stretch_chk #(
   .DATA_W     (DATA_W),
   .CNT_W      (CNT_W),
   .LOW_FLOOR  (LOW_FLOOR),
   .HOLD_FLOOR (HOLD_FLOOR)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .bus_ready   (bus_ready),
   .per_wr_n    (per_wr_n),
   .per_data    (per_data),
   .err_overrun (err_overrun)
);

// File: tb/wr_strobe_stretch_bench.sv
`timescale 1ns/1ps
module wr_strobe_stretch_bench;

   localparam int DW = 8;
   localparam int CW = 8;
   localparam int EXP_LOW_FLOOR  = (900000 + 8000 - 1) / 8000;
   localparam int EXP_HOLD_FLOOR = (50000 + 8000 - 1) / 8000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cs_n = 1'b1;
   logic          wr_n = 1'b1;
   logic [DW-1:0] bus_data = '0;
   logic [CW-1:0] cfg_low = '0;
   logic [CW-1:0] cfg_hold = '0;
   logic          bus_ready;
   logic          per_wr_n;
   logic [DW-1:0] per_data;
   logic          err_overrun;

   int  checks = 0;
   int  errors = 0;
   bit  exp_err = 1'b0;
   bit  finished = 1'b0;
   logic [DW-1:0] last_data = '0;

   always #4 clk = ~clk;

   wr_strobe_stretch u_wr_strobe_stretch (
      .clk          (clk),
      .rst_n        (rst_n),
      .bus_cs_n     (cs_n),
      .bus_wr_n     (wr_n),
      .bus_data     (bus_data),
      .cfg_low_cyc  (cfg_low),
      .cfg_hold_cyc (cfg_hold),
      .bus_ready    (bus_ready),
      .per_wr_n     (per_wr_n),
      .per_data     (per_data),
      .err_overrun  (err_overrun)
   );

   function automatic int exp_len(input int cfg, input int floor_v);
      return (cfg < floor_v) ? floor_v : cfg;
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // Caller stands at a falling edge; the write is driven immediately.
   task automatic run_write(input logic [DW-1:0] d, input int lc, input int hc,
                            input bit overlap);
      int lowc;
      int holdc;
      bit data_bad;
      bus_data = d;
      cfg_low  = CW'(lc);
      cfg_hold = CW'(hc);
      cs_n     = 1'b0;
      wr_n     = 1'b0;
      @(negedge clk);
      chk(!per_wr_n && !bus_ready, "R2", "strobe and stall start", {per_wr_n, bus_ready}, 0);
      chk(per_data == d, "R3", "captured data", per_data, d);
      lowc = 1;
      holdc = 0;
      data_bad = 1'b0;
      for (int k = 1; k < 2000; k++) begin
         if (k == 30) begin
            wr_n     = 1'b1;
            bus_data = DW'($urandom);
            cfg_low  = CW'($urandom);   // R10: must not affect this write
            cfg_hold = CW'($urandom);
         end
         if (overlap && k == 35) wr_n = 1'b0;
         if (overlap && k == 37) wr_n = 1'b1;
         @(negedge clk);
         if (per_data !== d) data_bad = 1'b1;
         if (bus_ready) break;
         if (!per_wr_n) lowc++;
         else holdc++;
      end
      if (overlap) exp_err = 1'b1;
      chk(lowc == exp_len(lc, EXP_LOW_FLOOR), "R4", "strobe low cycles", lowc,
          exp_len(lc, EXP_LOW_FLOOR));
      chk(holdc == exp_len(hc, EXP_HOLD_FLOOR), "R5", "hold cycles", holdc,
          exp_len(hc, EXP_HOLD_FLOOR));
      chk(!data_bad, overlap ? "R7" : "R3", "data held through sequence", data_bad, 0);
      chk(per_wr_n == 1'b1, "R6", "strobe high at release", per_wr_n, 1);
      chk(err_overrun == exp_err, "R7", "overrun flag", err_overrun, exp_err);
      last_data = d;
   endtask

   task automatic idle_check(input int n);
      repeat (n) @(negedge clk);
      chk(bus_ready && per_wr_n && per_data == last_data, "R6", "idle after release",
          {bus_ready, per_wr_n}, 3);
   endtask

   task automatic unselected(input logic [DW-1:0] d);
      cs_n     = 1'b1;
      bus_data = d;
      wr_n     = 1'b0;
      repeat (4) @(negedge clk);
      chk(bus_ready && per_wr_n && per_data == last_data, "R8", "unselected write ignored",
          per_data, last_data);
      wr_n = 1'b1;
      @(negedge clk);
      cs_n = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      void'($urandom(32'h5EED_0832));
      // R9: qualified strobe already active across reset release.
      cs_n = 1'b0;
      wr_n = 1'b0;
      repeat (3) @(negedge clk);
      chk(per_wr_n && bus_ready && per_data == 0 && !err_overrun, "R1", "reset state",
          {per_wr_n, bus_ready, err_overrun}, 6);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      chk(per_wr_n && bus_ready && !err_overrun, "R9", "held strobe not an edge",
          {per_wr_n, bus_ready}, 3);
      chk(per_data == 0, "R1", "data after reset", per_data, 0);
      wr_n = 1'b1;
      repeat (2) @(negedge clk);

      run_write(8'hA5, 0, 0, 1'b0);          // both floors apply
      idle_check(3);
      run_write(8'h3C, 113, 7, 1'b0);        // exactly at the floors
      run_write(8'h5A, 114, 8, 1'b0);        // R6: accepted in the first ready cycle
      idle_check(2);
      run_write(8'hFF, 255, 255, 1'b0);      // maximum counts
      idle_check(1);
      unselected(8'h11);
      run_write(8'h00, 200, 3, 1'b0);
      idle_check(2);
      run_write(8'h77, 120, 20, 1'b1);       // R7: overrun inside low phase
      idle_check(2);

      for (int n = 0; n < 30; n++) begin
         int gap;
         gap = int'($urandom % 4);
         if (($urandom % 6) == 0) unselected(DW'($urandom));
         if (gap != 0) idle_check(gap);
         run_write(DW'($urandom), int'($urandom % 256), int'($urandom % 256),
                   ($urandom % 4) == 0);
      end
      idle_check(3);

      if (!finished) begin
         finished = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         checks++;
         errors++;
         $display("FAIL R6 watchdog: actual %0d expected %0d", 0, 1);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule